// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block walks a block load or block store across a 16-entry register list. A pulse on `start` captures the list, a base byte address, and the direction. The block then issues one access per cycle on a 64-bit, always-hit data memory port until every selected register has been moved.

Registers are moved in ascending register number, one 32-bit word each, at consecutive word addresses from the base. A doubleword-aligned address moves two registers per cycle. A base in the upper half of a doubleword moves a single register in that upper word first. The address is aligned from then on.

The block is built for an in-order integer pipeline. `hold_first` stalls that pipeline only in the first cycle of the operation. After that, the pipeline compares `pending` against the source registers of later instructions. A register leaves `pending` in the very cycle it is transferred, and `done_strobe` marks that release. A consumer of a low-numbered register therefore waits less than a consumer of a high-numbered one.

Top module: `blkxfer_seq`

## Requirements
- R1: When `start` is high while `busy` is low, the next cycle has `busy` and `hold_first` high, and the captured list, base address and `is_store` value define the operation.
- R2: A `start` pulse while `busy` is high is ignored; the running operation continues unchanged.
- R3: Registers are transferred in ascending register number; the i-th selected register (counting from 0) uses byte address base + 4*i.
- R4: In a cycle whose current address has bit 2 clear, lane 0 (`mem_lane_en[0]`, low word at `mem_addr`+0) carries the lowest pending register and lane 1 (`mem_lane_en[1]`, upper word at `mem_addr`+4) carries the next one if it exists.
- R5: In a cycle whose current address has bit 2 set, only lane 1 is enabled (`mem_lane_en` = 2'b10), carrying exactly one register; the following address is the next doubleword.
- R6: For n selected registers the operation keeps `busy` high for ceil(n/2) cycles from an aligned base and floor(n/2)+1 cycles from a base with bit 2 set, and for 1 cycle when n = 0.
- R7: An empty list raises `busy` for one cycle with `mem_req` and `mem_lane_en` low throughout.
- R8: `done_strobe` has bit k high exactly in the cycle register k is transferred; `pending` shows the registers not yet transferred, excluding those transferred in the current cycle, and never gains bits during an operation.
- R9: `hold_first` is high only in the first busy cycle of each operation.
- R10: `mem_addr` is always a multiple of 8 and equals the current address with its low three bits cleared.
- R11: `mem_we` equals the `is_store` value captured at start for every access of the operation.
- R12: During and right after reset, `busy`, `hold_first`, `mem_req`, `mem_lane_en`, `done_strobe` and `pending` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| is_store | input | 1 | 1 = store, 0 = load |
| reg_list | input | 16 | Bit k selects register k |
| base_addr | input | 32 | Byte base address (word aligned) |
| busy | output | 1 | Operation in progress |
| hold_first | output | 1 | Stall request for the integer pipeline, first cycle only |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Doubleword byte address |
| mem_lane_en | output | 2 | Bit 0 low word, bit 1 upper word |
| mem_lo_reg | output | 4 | Register number in the low word |
| mem_hi_reg | output | 4 | Register number in the upper word |
| done_strobe | output | 16 | Registers transferred this cycle |
| pending | output | 16 | Registers still to be transferred |

## Verification
The bench builds the block with its default parameters: 16 registers and a 32-bit address. At that size the full list, single-register lists, sparse lists with gaps at both ends, and the empty list can all be driven directly. Each list is run from an aligned base and from a base with bit 2 set. This exercises both even and odd counts, so the extra misalignment cycle is seen where it costs a cycle and where it costs nothing. A start issued mid-operation and a store run cover the capture rules.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int NREG = 16;
    localparam int IDXW = $clog2(NREG);
    localparam int AW   = 32;
    localparam int DWB  = 3;              // byte offset bits of a 64-bit doubleword
    localparam int DWAW = AW - DWB;       // doubleword index width

    typedef struct packed {
        logic            en;
        logic [IDXW-1:0] idx;
    } lane_t;

    function automatic lane_t lowest_set(input logic [NREG-1:0] v);
        lane_t r;
        r = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.en  = 1'b1;
                r.idx = IDXW'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [NREG-1:0] lane_mask(input lane_t l);
        logic [NREG-1:0] m;
        m = '0;
        if (l.en) m[l.idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/blkxfer_pick.sv
module blkxfer_pick
    import blkxfer_pkg::*;
(
    input  logic [NREG-1:0] pend,
    input  logic            upper_half,
    output lane_t           lo_lane,
    output lane_t           hi_lane,
    output logic [NREG-1:0] xfer
);
    lane_t           first_l;
    lane_t           second_l;
    logic [NREG-1:0] rest;

    always_comb begin
        first_l  = lowest_set(pend);
        rest     = pend & ~lane_mask(first_l);
        second_l = lowest_set(rest);
        if (upper_half) begin
            lo_lane = '0;
            hi_lane = first_l;
        end else begin
            lo_lane = first_l;
            hi_lane = second_l;
        end
        xfer = lane_mask(lo_lane) | lane_mask(hi_lane);
    end
endmodule

// File: rtl/blkxfer_state.sv
module blkxfer_state
    import blkxfer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            is_store,
    input  logic [NREG-1:0] reg_list,
    input  logic [AW-1:0]   base_addr,
    input  logic [NREG-1:0] xfer,
    output logic [NREG-1:0] pend_q,
    output logic [DWAW-1:0] dw_q,
    output logic            upper_q,
    output logic            busy_q,
    output logic            first_q,
    output logic            we_q
);
    logic [NREG-1:0] pend_next;

    assign pend_next = pend_q & ~xfer;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            dw_q    <= '0;
            upper_q <= 1'b0;
            busy_q  <= 1'b0;
            first_q <= 1'b0;
            we_q    <= 1'b0;
        end else if (busy_q) begin
            pend_q  <= pend_next;
            dw_q    <= dw_q + DWAW'(1);
            upper_q <= 1'b0;
            first_q <= 1'b0;
            busy_q  <= |pend_next;
        end else if (start) begin
            pend_q  <= reg_list;
            dw_q    <= base_addr[AW-1:DWB];
            upper_q <= base_addr[2];
            first_q <= 1'b1;
            busy_q  <= 1'b1;
            we_q    <= is_store;
        end
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            is_store,
    input  logic [NREG-1:0] reg_list,
    input  logic [AW-1:0]   base_addr,
    output logic            busy,
    output logic            hold_first,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_lane_en,
    output logic [IDXW-1:0] mem_lo_reg,
    output logic [IDXW-1:0] mem_hi_reg,
    output logic [NREG-1:0] done_strobe,
    output logic [NREG-1:0] pending
);
    logic [NREG-1:0] pend_q;
    logic [DWAW-1:0] dw_q;
    logic            upper_q;
    logic            busy_q;
    logic            first_q;
    logic            we_q;
    lane_t           lo_lane;
    lane_t           hi_lane;
    logic [NREG-1:0] xfer;

    blkxfer_pick u_pick (
        .pend       (pend_q),
        .upper_half (upper_q),
        .lo_lane    (lo_lane),
        .hi_lane    (hi_lane),
        .xfer       (xfer)
    );

    blkxfer_state u_state (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_store  (is_store),
        .reg_list  (reg_list),
        .base_addr (base_addr),
        .xfer      (xfer),
        .pend_q    (pend_q),
        .dw_q      (dw_q),
        .upper_q   (upper_q),
        .busy_q    (busy_q),
        .first_q   (first_q),
        .we_q      (we_q)
    );

    assign busy        = busy_q;
    assign hold_first  = busy_q & first_q;
    assign mem_req     = busy_q & (|pend_q);
    assign mem_we      = we_q;
    assign mem_addr    = {dw_q, {DWB{1'b0}}};
    assign mem_lane_en = {hi_lane.en, lo_lane.en} & {2{busy_q}};
    assign mem_lo_reg  = lo_lane.idx;
    assign mem_hi_reg  = hi_lane.idx;
    assign done_strobe = busy_q ? xfer : '0;
    assign pending     = pend_q & ~done_strobe;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk
    import blkxfer_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            hold_first,
    input logic            mem_req,
    input logic            mem_we,
    input logic [AW-1:0]   mem_addr,
    input logic [1:0]      mem_lane_en,
    input logic [NREG-1:0] done_strobe,
    input logic [NREG-1:0] pending
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && hold_first)); // R1

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        busy |=> !hold_first); // R2

    AST_AT_MOST_TWO: assert property (@(posedge clk) disable iff (rst)
        $countones(done_strobe) <= 2); // R4

    AST_UPPER_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_lane_en == 2'b10) |-> $countones(done_strobe) == 1); // R5

    AST_STROBE_MATCH_LANES: assert property (@(posedge clk) disable iff (rst)
        $countones(done_strobe) == $countones(mem_lane_en)); // R8

    AST_PEND_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        busy |=> (pending & ~$past(pending)) == '0); // R8

    AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        hold_first |=> !hold_first); // R9

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[2:0] == 3'b000); // R10

    AST_WE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && !hold_first) |-> $stable(mem_we)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && mem_lane_en == 2'b00)); // R7
endmodule

bind blkxfer_seq blkxfer_seq_chk u_chk (.*);

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_store = 1'b0;
    logic [15:0] reg_list = '0;
    logic [31:0] base_addr = '0;
    logic        busy, hold_first, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_lane_en;
    logic [3:0]  mem_lo_reg, mem_hi_reg;
    logic [15:0] done_strobe, pending;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    blkxfer_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .is_store(is_store),
        .reg_list(reg_list), .base_addr(base_addr), .busy(busy),
        .hold_first(hold_first), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_lane_en(mem_lane_en),
        .mem_lo_reg(mem_lo_reg), .mem_hi_reg(mem_hi_reg),
        .done_strobe(done_strobe), .pending(pending)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference model
    int          mq[$];
    logic        m_busy = 0, m_first = 0, m_we = 0;
    logic [31:0] m_addr = 0;

    function automatic int m_count();
        if (!m_busy || mq.size() == 0) return 0;
        if (m_addr[2]) return 1;
        return (mq.size() >= 2) ? 2 : 1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            mq.delete(); m_busy = 0; m_first = 0; m_we = 0; m_addr = 0;
        end else if (m_busy) begin
            int n;
            n = m_count();
            for (int i = 0; i < n; i++) void'(mq.pop_front());
            m_addr  = (m_addr & ~32'd7) + 32'd8;
            m_first = 0;
            m_busy  = (mq.size() != 0);
        end else if (start) begin
            mq.delete();
            for (int k = 0; k < 16; k++) if (reg_list[k]) mq.push_back(k);
            m_addr = base_addr; m_we = is_store; m_busy = 1; m_first = 1;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            chk(!busy && !hold_first && !mem_req && mem_lane_en == 0, "R12 reset outputs",
                {busy, hold_first, mem_req, mem_lane_en}, 0);
            chk(done_strobe == 0 && pending == 0, "R12 reset masks", {done_strobe, pending}, 0);
        end else begin
            int          n;
            logic [1:0]  e_en;
            logic [15:0] e_done, e_pend;
            n = m_count();
            e_en = 2'b00;
            if (n == 2) e_en = 2'b11;
            else if (n == 1) e_en = m_addr[2] ? 2'b10 : 2'b01;
            e_done = 0;
            for (int i = 0; i < n; i++) e_done[mq[i]] = 1'b1;
            e_pend = 0;
            for (int i = n; i < mq.size(); i++) e_pend[mq[i]] = 1'b1;
            chk(busy == m_busy, "R1 busy", busy, m_busy);
            chk(hold_first == (m_busy && m_first), "R9 hold_first", hold_first, m_busy && m_first);
            chk(mem_req == (m_busy && mq.size() != 0), "R7 mem_req", mem_req, m_busy && mq.size() != 0);
            chk(mem_lane_en == e_en, "R4/R5 lane enables", mem_lane_en, e_en);
            chk(done_strobe == e_done, "R8 done_strobe", done_strobe, e_done);
            chk(pending == e_pend, "R8 pending", pending, e_pend);
            if (n > 0) begin
                chk(mem_addr == (m_addr & ~32'd7), "R10 mem_addr", mem_addr, m_addr & ~32'd7);
                chk(mem_we == m_we, "R11 mem_we", mem_we, m_we);
                if (e_en[0]) chk(mem_lo_reg == mq[0], "R3 low lane register", mem_lo_reg, mq[0]);
                if (e_en[1]) chk(mem_hi_reg == (m_addr[2] ? mq[0] : mq[1]), "R3 upper lane register",
                                 mem_hi_reg, m_addr[2] ? mq[0] : mq[1]);
            end
        end
    end

    task automatic run_op(input logic [15:0] lst, input logic [31:0] base, input logic st,
                          input int intrude_at);
        int n, exp_cyc, cnt;
        n = $countones(lst);
        if (n == 0) exp_cyc = 1;
        else if (base[2]) exp_cyc = n / 2 + 1;
        else exp_cyc = (n + 1) / 2;
        @(negedge clk);
        reg_list = lst; base_addr = base; is_store = st; start = 1;
        @(negedge clk);
        start = 0; reg_list = 16'hFFFF; base_addr = 32'h0000_0104; is_store = ~st;
        cnt = 0;
        while (busy && cnt < 64) begin
            cnt++;
            if (cnt == intrude_at) start = 1;   // R2: must be ignored
            @(negedge clk);
            start = 0;
        end
        chk(cnt == exp_cyc, "R6 cycle count", cnt, exp_cyc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        @(posedge clk);
        #1 rst = 0;
        run_op(16'hFFFF, 32'h0000_1000, 0, 0);   // R4 aligned, full list
        run_op(16'hFFFF, 32'h0000_1004, 0, 0);   // R5 misaligned, even count
        run_op(16'h0007, 32'h0000_2004, 1, 0);   // R5 misaligned, odd count, store R11
        run_op(16'h0007, 32'h0000_2000, 1, 0);   // R6 odd aligned
        run_op(16'h0000, 32'h0000_3000, 0, 0);   // R7 empty
        run_op(16'h0000, 32'h0000_3004, 1, 0);   // R7 empty misaligned
        run_op(16'h8000, 32'h0000_4004, 0, 0);   // R3 single high register
        run_op(16'h0001, 32'h0000_4000, 0, 0);   // single low register
        run_op(16'h8421, 32'hFFFF_FFF4, 1, 0);   // R3 sparse, address wrap
        run_op(16'hA5A5, 32'h0000_5000, 0, 2);   // R2 start while busy
        run_op(16'h3C00, 32'h0000_6004, 1, 1);   // R2 start in first cycle
        @(posedge clk);
        #1 rst = 1;
        @(negedge clk);                          // R12 reset during idle
        @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(!busy && pending == 0, "R12 after reset", {busy, pending}, 0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule